// File: doc/BRIEF.md
# Three-Wire Command/Status Serial Port

This block lets a host controller write an 8-bit command register and read an 8-bit status register over three wires: a serial clock, a load line and one data line. The level of the load line sets the direction. With load high, the host shifts a command byte in, most significant bit first, one bit per rising serial-clock edge. It then drops load to commit the byte. With load low and no complete byte pending, the block captures the status sources and drives them out, most significant bit first, advancing one bit per rising serial-clock edge. A transaction ends when clock and load are both high again.

All host-side lines are asynchronous to the system clock. Each one passes through a two-stage synchroniser, and edges are detected in the system clock domain. The command register comes out of reset with only the bypass bit set, so the device starts in bypass. Two command bits, flush and position-found, are strobes that clear themselves the cycle after they are committed. After the eighth status bit has been shifted out, the block issues a one-cycle read pulse. The status sources use this pulse to clear their clear-on-read flags (framing error, new frame, full).

Top module: `cmd_status_port`

## Requirements
- R1: After reset, `cmdOut` is 8'h40 (only bit 6, bypass, set), `hostDataOe` is low and `statusReadPulse` is low.
- R2: While `hostLoad` is high, each rising edge of `hostClk` samples `hostDataIn`; the first sampled bit becomes command bit 7 and the eighth becomes bit 0.
- R3: A falling edge of `hostLoad` after at least eight sampled bits copies the shifted byte into `cmdOut`; after fewer than eight, `cmdOut` is unchanged.
- R4: When more than eight bits are shifted in before load falls, the last eight are committed.
- R5: Command bit 7 (flush) and bit 0 (position-found) are high for exactly one system clock cycle after a commit, then read as 0.
- R6: Command bits 6 to 1 (bypass, echo, jump-busy, off-track polarity, rotational-shock enable, host-shock) keep their value until the next commit.
- R7: A falling edge of `hostLoad` that does not commit a write captures `statusIn`, raises `hostDataOe` and drives status bit 7. Each later rising `hostClk` edge while load is low advances to the next lower bit.
- R8: After the eighth rising `hostClk` edge of a read, `statusReadPulse` is high for one cycle. Further clock edges in the same read give no more pulses.
- R9: A rising edge of `hostLoad` releases `hostDataOe` and ends the transaction.
- R10: A change of `statusIn` after the capture does not change the bits being shifted out.
- R11: Rising `hostClk` edges while load is low after a committed write do not enable the data line and give no read pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostClk | input | 1 | Host serial clock, asynchronous |
| hostLoad | input | 1 | Host load/direction line, asynchronous |
| hostDataIn | input | 1 | Data line as seen at the pad input |
| statusIn | input | 8 | Live status sources: bit 7/6 FIFO level MSBs, 5 framing error, 4 new frame, 3 full, 2 empty, 1 shock detected, 0 fill |
| cmdOut | output | 8 | Command bits: 7 flush, 6 bypass, 5 echo, 4 jump-busy, 3 off-track polarity, 2 rotational-shock enable, 1 host-shock, 0 position-found |
| statusReadPulse | output | 1 | One-cycle pulse once a full status byte has been read |
| hostDataOut | output | 1 | Value driven onto the data line during a read |
| hostDataOe | output | 1 | Data line drive enable |

## Verification
A wrong bit counter shows at the ports as a commit that lands one bit off: a shifted byte, an unchanged register, or a read pulse that is missing or doubled. It appears about three system cycles after the load or clock edge that triggers it. A wrong direction state shows up as the drive enable toggling at the wrong load edge. A failed self-clear shows as flush or position-found staying high into the next cycle. The reference model replays the host lines through the same synchroniser latency and compares every output on every clock, so each of these faults is caught within a cycle of its first effect.

// File: rtl/csp_pkg.sv
package csp_pkg;
  // Strobes from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic shiftIn;     // sample one host data bit into the write shifter
    logic latchCmd;    // commit write shifter to the command register
    logic snapStatus;  // capture status sources for a read
    logic shiftOut;    // advance the read shifter by one bit
  } csp_strobe_t;
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int               WIDTH     = 3,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chainQ;
  logic [WIDTH-1:0]   prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= RESET_VAL;
        else       chainQ <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chainQ <= {STAGES{RESET_VAL}};
        else       chainQ <= {chainQ[CHAIN_W-WIDTH-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chainQ[CHAIN_W-1 -: WIDTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= RESET_VAL;
    else       prevQ <= syncOut;
  end

  assign prevOut = prevQ;
endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import csp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ckLvl,
  input  logic        ckPrev,
  input  logic        ldLvl,
  input  logic        ldPrev,
  output csp_strobe_t strobe,
  output logic        driveEn,
  output logic        readDone
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic             ckRise, ldFall, ldRise, ldEdge;
  logic             wrFull, rdMore;
  logic [CNT_W-1:0] wrCnt, rdCnt;

  assign ckRise = ckLvl & ~ckPrev;
  assign ldFall = ldPrev & ~ldLvl;
  assign ldRise = ~ldPrev & ldLvl;
  assign ldEdge = ldFall | ldRise;
  assign wrFull = (wrCnt == CNT_FULL);
  assign rdMore = (rdCnt < CNT_FULL);

  // Load edges take priority over a clock edge seen in the same cycle.
  always_comb begin
    strobe            = '0;
    strobe.latchCmd   = ldFall & wrFull;
    strobe.snapStatus = ldFall & ~wrFull;
    strobe.shiftIn    = ckRise & ldLvl & ~ldEdge;
    strobe.shiftOut   = ckRise & ~ldLvl & ~ldEdge & driveEn & rdMore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt    <= '0;
      rdCnt    <= '0;
      driveEn  <= 1'b0;
      readDone <= 1'b0;
    end else begin
      readDone <= strobe.shiftOut & (rdCnt == CNT_LAST);
      if (ldEdge)                          wrCnt <= '0;
      else if (strobe.shiftIn && !wrFull)  wrCnt <= wrCnt + 1'b1;
      if (ldEdge)                          rdCnt <= '0;
      else if (strobe.shiftOut)            rdCnt <= rdCnt + 1'b1;
      if (strobe.snapStatus)               driveEn <= 1'b1;
      else if (ldRise)                     driveEn <= 1'b0;
    end
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> !readDone);

  assert_pulse_in_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    readDone |-> driveEn);

  assert_release_on_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    ldRise |=> !driveEn);

  assert_no_drive_in_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ldLvl && !ldEdge) |=> !readDone);
endmodule

// File: rtl/csp_dpath.sv
module csp_dpath
  import csp_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter logic [DATA_W-1:0] CMD_RESET     = 8'h40,
  parameter logic [DATA_W-1:0] SELF_CLR_MASK = 8'h81
) (
  input  logic              clk,
  input  logic              rstN,
  input  csp_strobe_t       strobe,
  input  logic              dataBit,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] cmdOut,
  output logic              serialOut
);
  localparam logic [DATA_W-1:0] HOLD_MASK = ~SELF_CLR_MASK;

  logic [DATA_W-1:0] wrShift, rdShift, cmdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrShift <= '0;
      rdShift <= '0;
      cmdReg  <= CMD_RESET;
    end else begin
      if (strobe.shiftIn)    wrShift <= {wrShift[DATA_W-2:0], dataBit};
      if (strobe.latchCmd)   cmdReg  <= wrShift;
      else                   cmdReg  <= cmdReg & HOLD_MASK;
      if (strobe.snapStatus) rdShift <= statusIn;
      else if (strobe.shiftOut) rdShift <= {rdShift[DATA_W-2:0], 1'b0};
    end
  end

  assign cmdOut    = cmdReg;
  assign serialOut = rdShift[DATA_W-1];

  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdReg & SELF_CLR_MASK) != '0) |=> ((cmdReg & SELF_CLR_MASK) == '0));

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCmd |=> ((cmdReg & HOLD_MASK) == $past(cmdReg & HOLD_MASK)));
endmodule

// File: rtl/cmd_status_port.sv
module cmd_status_port
  import csp_pkg::*;
#(
  parameter int                DATA_W        = 8,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [DATA_W-1:0] CMD_RESET     = 8'h40,
  parameter logic [DATA_W-1:0] SELF_CLR_MASK = 8'h81
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostClk,
  input  logic              hostLoad,
  input  logic              hostDataIn,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] cmdOut,
  output logic              statusReadPulse,
  output logic              hostDataOut,
  output logic              hostDataOe
);
  // Line order inside the synchroniser: {data, load, clock}; idle is clock and load high.
  localparam logic [2:0] LINE_IDLE = 3'b011;

  logic [2:0]  lineSync, linePrev;
  csp_strobe_t strobe;

  csp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(LINE_IDLE)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({hostDataIn, hostLoad, hostClk}),
    .syncOut(lineSync), .prevOut(linePrev)
  );

  csp_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .ckLvl(lineSync[0]), .ckPrev(linePrev[0]),
    .ldLvl(lineSync[1]), .ldPrev(linePrev[1]),
    .strobe(strobe), .driveEn(hostDataOe), .readDone(statusReadPulse)
  );

  csp_dpath #(.DATA_W(DATA_W), .CMD_RESET(CMD_RESET), .SELF_CLR_MASK(SELF_CLR_MASK)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dataBit(lineSync[2]), .statusIn(statusIn),
    .cmdOut(cmdOut), .serialOut(hostDataOut)
  );
endmodule

// File: tb/test_cmd_status_port.sv
`timescale 1ns/1ps
module test_cmd_status_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostClk = 1'b1, hostLoad = 1'b1, hostDataIn = 1'b0;
  logic [7:0] statusIn = 8'h00;
  logic [7:0] cmdOut;
  logic       statusReadPulse, hostDataOut, hostDataOe;

  int    nChecks = 0, nFails = 0, cycles = 0, pulseCnt = 0;
  bit    finished = 0;
  string phaseTag = "R1";

  always #10 clk = ~clk;

  cmd_status_port i_cmd_status_port (
    .clk(clk), .rstN(rstN), .hostClk(hostClk), .hostLoad(hostLoad),
    .hostDataIn(hostDataIn), .statusIn(statusIn), .cmdOut(cmdOut),
    .statusReadPulse(statusReadPulse), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // Reference model: host lines seen after two synchroniser stages plus edge register.
  logic [4:0] hCk = 5'h1F, hLd = 5'h1F, hD = 5'h00;
  logic [7:0] hSt [5];
  logic [7:0] mCmd = 8'h40, mShift = 8'h00, mSnap = 8'h00;
  logic       mOe = 0, mPulse = 0;
  int         mWr = 0, mRd = 0;

  always @(negedge clk) begin
    logic cPrev, cCur, lPrev, lCur;
    hCk = {hCk[3:0], hostClk};
    hLd = {hLd[3:0], hostLoad};
    hD  = {hD[3:0], hostDataIn};
    for (int i = 4; i > 0; i--) hSt[i] = hSt[i-1];
    hSt[0] = statusIn;
    if (!rstN) begin
      mCmd = 8'h40; mShift = 0; mSnap = 0; mOe = 0; mPulse = 0; mWr = 0; mRd = 0;
    end else begin
      mCmd = mCmd & 8'h7E;
      mPulse = 0;
      cPrev = hCk[4]; cCur = hCk[3]; lPrev = hLd[4]; lCur = hLd[3];
      if (lPrev && !lCur) begin
        if (mWr == 8) mCmd = mShift;
        else begin mOe = 1; mSnap = hSt[1]; end
        mWr = 0; mRd = 0;
      end else if (!lPrev && lCur) begin
        mOe = 0; mWr = 0; mRd = 0;
      end else if (!cPrev && cCur) begin
        if (lCur) begin
          mShift = {mShift[6:0], hD[3]};
          if (mWr < 8) mWr++;
        end else if (mOe && mRd < 8) begin
          mRd++;
          if (mRd == 8) mPulse = 1;
        end
      end
      chk(cmdOut === mCmd, phaseTag, "cmdOut", cmdOut, mCmd);
      chk(hostDataOe === mOe, phaseTag, "hostDataOe", hostDataOe, mOe);
      chk(statusReadPulse === mPulse, phaseTag, "statusReadPulse", statusReadPulse, mPulse);
      if (mOe) chk(hostDataOut === ((mRd < 8) ? mSnap[7-mRd] : 1'b0), phaseTag,
                   "hostDataOut", hostDataOut, (mRd < 8) ? mSnap[7-mRd] : 1'b0);
    end
    if (statusReadPulse) pulseCnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      summary();
    end
  end

  task automatic setPins(input logic c, input logic l, input logic d, input int n);
    @(posedge clk); #2;
    hostClk = c; hostLoad = l; hostDataIn = d;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic writeBits(input logic [15:0] val, input int nBits, input bit commit);
    setPins(1, 1, 0, 4);
    for (int i = nBits - 1; i >= 0; i--) begin
      setPins(0, 1, val[i], 4);
      setPins(1, 1, val[i], 4);
    end
    if (commit) setPins(1, 0, 0, 6);
  endtask

  task automatic endTxn();
    setPins(1, 1, 0, 6);
  endtask

  task automatic readByte(output logic [7:0] got, input int extra,
                          input bit doChange, input logic [7:0] newStatus);
    got = 8'h00;
    setPins(1, 0, 0, 6);
    for (int i = 0; i < 8 + extra; i++) begin
      setPins(0, 0, 0, 4);
      @(negedge clk);
      if (i < 8) got[7-i] = hostDataOut;
      if (doChange && i == 3) statusIn = newStatus;
      setPins(1, 0, 0, 4);
    end
  endtask

  initial begin
    logic [7:0] got;
    for (int i = 0; i < 5; i++) hSt[i] = 8'h00;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(cmdOut == 8'h40, "R1", "reset cmdOut", cmdOut, 8'h40);
    chk(hostDataOe == 1'b0, "R1", "reset hostDataOe", hostDataOe, 0);
    chk(statusReadPulse == 1'b0, "R1", "reset statusReadPulse", statusReadPulse, 0);

    phaseTag = "R2";
    writeBits(16'h003C, 8, 1); endTxn();
    chk(cmdOut == 8'h3C, "R2", "write 3C msb first", cmdOut, 8'h3C);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(cmdOut == 8'h3C, "R6", "held bits", cmdOut, 8'h3C);

    phaseTag = "R5";
    writeBits(16'h00D3, 8, 1); endTxn();
    chk(cmdOut == 8'h52, "R5", "flush and found self-cleared", cmdOut, 8'h52);

    phaseTag = "R3";
    writeBits(16'h0015, 5, 1);
    @(negedge clk);
    chk(cmdOut == 8'h52, "R3", "short write ignored", cmdOut, 8'h52);
    chk(hostDataOe == 1'b1, "R7", "short write starts read", hostDataOe, 1);
    endTxn();
    @(negedge clk);
    chk(hostDataOe == 1'b0, "R9", "load rise releases line", hostDataOe, 0);

    phaseTag = "R4";
    writeBits(16'h0366, 10, 1); endTxn();
    chk(cmdOut == 8'h66, "R4", "last eight of ten", cmdOut, 8'h66);

    phaseTag = "R7";
    statusIn = 8'hB6;
    pulseCnt = 0;
    readByte(got, 0, 0, 8'h00);
    chk(got == 8'hB6, "R7", "status byte read", got, 8'hB6);
    endTxn();
    chk(pulseCnt == 1, "R8", "one read pulse", pulseCnt, 1);

    phaseTag = "R10";
    statusIn = 8'h5A;
    pulseCnt = 0;
    readByte(got, 3, 1, 8'h00);
    chk(got == 8'h5A, "R10", "snapshot kept", got, 8'h5A);
    endTxn();
    chk(pulseCnt == 1, "R8", "extra clocks no extra pulse", pulseCnt, 1);

    phaseTag = "R11";
    pulseCnt = 0;
    writeBits(16'h0024, 8, 1);
    for (int i = 0; i < 9; i++) begin
      setPins(0, 0, 0, 4);
      setPins(1, 0, 0, 4);
      @(negedge clk);
      chk(hostDataOe == 1'b0, "R11", "no drive after commit", hostDataOe, 0);
    end
    endTxn();
    chk(pulseCnt == 0, "R11", "no pulse after commit", pulseCnt, 0);
    chk(cmdOut == 8'h24, "R6", "value after commit", cmdOut, 8'h24);

    repeat (5) @(posedge clk);
    summary();
  end
endmodule